// File: doc/BRIEF.md
# Three-Way Digital Phase Comparator

This block compares a reference input against a feedback input and reports their phase relation through three detectors that run side by side on one system clock. Both inputs arrive asynchronously. Each passes through its own synchroniser and rising-edge finder, and every detector then works from those clean, clock-aligned samples.

The first detector is a level comparison that mismatches whenever the two synchronised levels differ. The second is an edge-driven up/down phase-frequency detector. Its three-state output is carried as an enable bit and a value bit, and a lock pulse output sits high whenever that detector is not correcting. The third is a set/clear sequential detector that idles at half duty when the inputs are aligned. A loop filter outside the block averages whichever output the system selects. The pins here are plain control levels with no streaming handshake, so no back-pressure rules apply.

All timing below is counted in rising edges of `clk`. An input level that is first sampled on edge k, with the input changed away from any clock edge, becomes visible at the outputs just after edge k+2.

Top module: `tri_phase_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `xor_out`, `pfd_drive_en`, `pfd_drive_val` and `seq_out` are 0 and `lock_pulse` is 1.
- R2: After edge k+2, `xor_out` equals the XOR of the `ref_in` and `fb_in` levels sampled at edge k.
- R3: A reference rising edge first sampled at edge k, with no feedback edge in the same cycle and no pending down request, gives `pfd_drive_en`=1 and `pfd_drive_val`=1 (drive high) after edge k+2.
- R4: A feedback rising edge with no reference edge in the same cycle and no pending up request gives `pfd_drive_en`=1 and `pfd_drive_val`=0 (drive low), with the same latency as R3.
- R5: The up and down requests are never active together. An edge on the opposite input cancels the pending request, and the output returns to the floating state (`pfd_drive_en`=0).
- R6: Reference and feedback rising edges that fall in the same cycle leave the phase-frequency detector state unchanged.
- R7: `lock_pulse` is always the inverse of `pfd_drive_en`, and it stays 1 while both inputs are identical.
- R8: `seq_out` becomes 1 after a lone reference rising edge and 0 after a lone feedback rising edge. With equal periods, its high time per period equals the delay from the reference edge to the next feedback edge.
- R9: Coincident rising edges toggle `seq_out`, so identical inputs give a 50% average on it.
- R10: With equal frequencies, the drive-high (lead) or drive-low (lag) time per period equals the edge offset in clock cycles, whatever the input duty cycles are.
- R11: With no reference activity and a running feedback, the detectors settle at drive-low (`pfd_drive_en`=1, `pfd_drive_val`=0) and `seq_out`=0.
- R12: A faster reference gives more drive-high cycles than drive-low cycles, and a slower reference gives the reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Asynchronous reference input |
| fb_in | input | 1 | Asynchronous feedback input |
| xor_out | output | 1 | Level-comparison detector output |
| pfd_drive_en | output | 1 | Phase-frequency detector drives when 1, floats when 0 |
| pfd_drive_val | output | 1 | Driven level of the phase-frequency detector (1 high, 0 low) |
| seq_out | output | 1 | Set/clear sequential detector output |
| lock_pulse | output | 1 | High while the phase-frequency detector is idle (in-lock sign) |

## Verification
The event that needs care is a reference rising edge and a feedback rising edge landing in the same clock cycle. Both edge-driven detectors have to resolve it: the phase-frequency detector must hold its state, and the sequential detector must toggle. The bench provokes this by driving identical waveforms on both inputs. It then judges the result cycle by cycle against a behavioural up/down-count model, requires the drive enable to stay low with the lock pulse high, and requires `seq_out` to be high for exactly half of a whole number of periods.

// File: rtl/phcmp_pkg.sv
package phcmp_pkg;
  // Pending correction request of the phase-frequency detector.
  typedef enum logic [1:0] {
    REQ_NONE = 2'b00,
    REQ_UP   = 2'b01,
    REQ_DOWN = 2'b10
  } pfd_req_t;

  localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic rise_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;
  logic          prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[LAST];
  end

  assign level_o = chain[LAST];
  assign rise_o  = chain[LAST] & ~prev_q;

  // R3: a detected rising edge lasts exactly one cycle
  p_edge_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/level_xor_det.sv
module level_xor_det (
  input  logic clk,
  input  logic rst_n,
  input  logic a_lvl,
  input  logic b_lvl,
  output logic mismatch_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) mismatch_o <= 1'b0;
    else        mismatch_o <= a_lvl ^ b_lvl;
  end

  // R2: two equal levels never leave a mismatch behind
  p_equal_no_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (a_lvl == b_lvl) |=> !mismatch_o);
endmodule

// File: rtl/updown_pfd.sv
module updown_pfd
  import phcmp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic drive_en_o,
  output logic drive_val_o
);
  pfd_req_t req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (ref_rise && !fb_rise) begin
      req_d = (req_q == REQ_DOWN) ? REQ_NONE : REQ_UP;
    end else if (fb_rise && !ref_rise) begin
      req_d = (req_q == REQ_UP) ? REQ_NONE : REQ_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= REQ_NONE;
    else        req_q <= req_d;
  end

  assign drive_en_o  = (req_q != REQ_NONE);
  assign drive_val_o = (req_q == REQ_UP);

  // R5: never up and down at once
  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_q != 2'b11);
  // R3: lone reference edge without pending down drives high
  p_ref_sets_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise && req_q != REQ_DOWN) |=> (drive_en_o && drive_val_o));
  // R4: lone feedback edge without pending up drives low
  p_fb_sets_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise && req_q != REQ_UP) |=> (drive_en_o && !drive_val_o));
  // R5: opposite edge returns to float
  p_cancel_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == REQ_UP && fb_rise && !ref_rise) |=> !drive_en_o);
  // R6: coincident edges leave the state alone
  p_coincident_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> ($stable(drive_en_o) && $stable(drive_val_o)));
endmodule

// File: rtl/setclr_det.sv
module setclr_det (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)                  q_o <= 1'b0;
    else if (ref_rise && fb_rise) q_o <= ~q_o;
    else if (ref_rise)           q_o <= 1'b1;
    else if (fb_rise)            q_o <= 1'b0;
  end

  // R8: lone edges set and clear
  p_ref_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !fb_rise) |=> q_o);
  p_fb_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_rise && !ref_rise) |=> !q_o);
  // R9: coincident edges flip the output
  p_coincident_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && fb_rise) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/tri_phase_detector.sv
module tri_phase_detector
  import phcmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic fb_in,
  output logic xor_out,
  output logic pfd_drive_en,
  output logic pfd_drive_val,
  output logic seq_out,
  output logic lock_pulse
);
  localparam int STAGES = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic ref_lvl, ref_rise, fb_lvl, fb_rise;

  edge_sync #(.STAGES(STAGES)) u_ref_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ref_in),
    .level_o(ref_lvl), .rise_o(ref_rise)
  );

  edge_sync #(.STAGES(STAGES)) u_fb_sync (
    .clk(clk), .rst_n(rst_n), .async_in(fb_in),
    .level_o(fb_lvl), .rise_o(fb_rise)
  );

  level_xor_det u_xor (
    .clk(clk), .rst_n(rst_n), .a_lvl(ref_lvl), .b_lvl(fb_lvl),
    .mismatch_o(xor_out)
  );

  updown_pfd u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .drive_en_o(pfd_drive_en), .drive_val_o(pfd_drive_val)
  );

  setclr_det u_seq (
    .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .q_o(seq_out)
  );

  assign lock_pulse = ~pfd_drive_en;

  // R1: everything idle in the cycle after a reset edge
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!xor_out && !pfd_drive_en && !seq_out && lock_pulse));
endmodule

// File: tb/tri_phase_detector_test.sv
module tri_phase_detector_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic xor_out, pfd_drive_en, pfd_drive_val, seq_out, lock_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tri_phase_detector uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .xor_out(xor_out), .pfd_drive_en(pfd_drive_en), .pfd_drive_val(pfd_drive_val),
    .seq_out(seq_out), .lock_pulse(lock_pulse)
  );

  // Behavioural model: sample history plus a saturating up/down count.
  bit rq[$];
  bit fq[$];
  int m_cnt = 0;
  bit m_xor = 1'b0;
  bit m_seq = 1'b0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      rq.push_front(1'b0);
      fq.push_front(1'b0);
    end
  end

  always @(posedge clk) begin
    bit re, fe;
    rq.push_front(rst_n ? ref_in : 1'b0);
    fq.push_front(rst_n ? fb_in : 1'b0);
    void'(rq.pop_back());
    void'(fq.pop_back());
    if (!rst_n) begin
      m_cnt = 0; m_xor = 1'b0; m_seq = 1'b0;
    end else begin
      re = rq[2] && !rq[3];
      fe = fq[2] && !fq[3];
      m_xor = rq[2] ^ fq[2];
      m_cnt = m_cnt + int'(re) - int'(fe);
      if (m_cnt > 1) m_cnt = 1;
      if (m_cnt < -1) m_cnt = -1;
      if (re && fe) m_seq = !m_seq;
      else if (re) m_seq = 1'b1;
      else if (fe) m_seq = 1'b0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      check("R2 xor_out", xor_out, m_xor);
      check("R3/R4 pfd_drive_en", pfd_drive_en, m_cnt != 0);
      check("R3/R4 pfd_drive_val", pfd_drive_val, m_cnt == 1);
      check("R7 lock_pulse", lock_pulse, m_cnt == 0);
      check("R8 seq_out", seq_out, m_seq);
    end
  end

  int up_n, dn_n, seq_n, lock_n;

  task automatic run_wave(input int rp, input int roff, input int rhi,
                          input int fp, input int foff, input int fhi,
                          input bit ref_on, input int warm, input int win);
    up_n = 0; dn_n = 0; seq_n = 0; lock_n = 0;
    for (int t = 0; t < warm + win; t++) begin
      @(negedge clk);
      if (t >= warm) begin
        if (pfd_drive_en && pfd_drive_val) up_n++;
        if (pfd_drive_en && !pfd_drive_val) dn_n++;
        if (seq_out) seq_n++;
        if (lock_pulse) lock_n++;
      end
      ref_in = ref_on && (((t + 1000 * rp - roff) % rp) < rhi);
      fb_in  = ((t + 1000 * fp - foff) % fp) < fhi;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 xor_out", xor_out, 0);
    check("R1 pfd_drive_en", pfd_drive_en, 0);
    check("R1 pfd_drive_val", pfd_drive_val, 0);
    check("R1 seq_out", seq_out, 0);
    check("R1 lock_pulse", lock_pulse, 1);
    rst_n = 1'b1;

    // R10 lead by 3 cycles, unequal duty cycles
    run_wave(16, 0, 2, 16, 3, 10, 1'b1, 48, 160);
    check("R10 lead drive-high cycles", up_n, 30);
    check("R10 lead drive-low cycles", dn_n, 0);
    check("R8 lead seq high cycles", seq_n, 30);

    // R10 lag by 5 cycles
    run_wave(16, 5, 9, 16, 0, 3, 1'b1, 48, 160);
    check("R10 lag drive-low cycles", dn_n, 50);
    check("R10 lag drive-high cycles", up_n, 0);
    check("R8 lag seq high cycles", seq_n, 110);

    // R6, R7, R9 identical inputs: coincident edges every period
    run_wave(16, 0, 8, 16, 0, 8, 1'b1, 48, 160);
    check("R6 identical drive cycles", up_n + dn_n, 0);
    check("R7 identical lock cycles", lock_n, 160);
    check("R9 identical seq high cycles", seq_n, 80);

    // R12 reference faster, then slower
    run_wave(12, 0, 6, 16, 0, 8, 1'b1, 48, 480);
    check("R12 faster ref up>down", up_n > dn_n, 1);
    run_wave(20, 0, 10, 16, 0, 8, 1'b1, 48, 480);
    check("R12 slower ref down>up", dn_n > up_n, 1);

    // R11 missing reference
    run_wave(16, 0, 8, 16, 0, 8, 1'b0, 48, 160);
    check("R11 drive-low cycles", dn_n, 160);
    check("R11 seq high cycles", seq_n, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule